// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns supply-health indications and watchdog timeout requests into a processor reset. Comparators outside the block report the supply state as synchronous digital flags: `low_line` (supply below its threshold), `on_battery` (main supply below the backup source) and `pfi_low` (early power-fail monitor tripped). While either supply flag is set, reset is held. Once both flags clear, reset is stretched for a fixed number of timebase ticks. A watchdog timeout request uses the same stretcher to produce one reset pulse of the same width.

The block counts enable pulses on `tick`, which comes from a slow timebase of nominally 10.24 kHz. With 512 ticks this gives a stretch of about 50 ms. The reset is driven on two outputs of opposite polarity. When the stretch ends, a one-cycle strobe tells the watchdog block that reset has been released.

The same supply flags gate a memory chip-enable, so that writes are blocked while the supply is invalid. They also drive a power-fail flag, which is forced active in battery mode. All outputs are registered and change on the clock edge after their inputs change.

Top module: `supv_reset_gen`

## Requirements
- R1: While `low_line` or `on_battery` is 1 at a clock edge, `reset` is 1 after that edge. `tick` pulses seen in that state do not advance the stretch.
- R2: After both supply flags are 0, `reset` stays 1 until STRETCH_TICKS (default 512) edges have seen `tick`=1. It goes to 0 on the edge where the last of those ticks is seen.
- R3: A one-cycle `wd_req`=1 while `reset` is 0 and the supply is good sets `reset` to 1 after that edge. The pulse then releases after STRETCH_TICKS ticks.
- R4: `reset_n` is always the inverse of `reset`.
- R5: `ce_out_n` equals `ce_in_n` (active low) from the previous edge while both supply flags are 0. It is 1 after any edge at which `low_line` or `on_battery` is 1.
- R6: `pf_out_n` is 0 after any edge at which `pfi_low` or `on_battery` is 1, and 1 otherwise.
- R7: `low_line_out` equals `low_line` sampled at the previous edge.
- R8: If `low_line` returns to 1 during the stretch, the tick count is discarded. A full STRETCH_TICKS count starts again only after the flag clears.
- R9: A `wd_req` arriving while `reset` is 1 does not move the release point of the reset in progress.
- R10: `reset_end` is 1 for exactly one cycle: the first cycle in which `reset` is 0 after being 1.
- R11: While `rst` is 1, the outputs are `reset`=1, `reset_n`=0, `ce_out_n`=1, `pf_out_n`=0, `low_line_out`=1 and `reset_end`=0. After `rst` falls, a full stretch of STRETCH_TICKS ticks is still needed before reset releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Timebase enable pulse, one per timebase period |
| low_line | input | 1 | Supply below its low-line threshold |
| on_battery | input | 1 | Main supply below backup source |
| pfi_low | input | 1 | Power-fail monitor input below threshold |
| wd_req | input | 1 | Watchdog timeout request, one-cycle pulse |
| ce_in_n | input | 1 | Memory chip-enable in, active low |
| reset | output | 1 | Processor reset, active high |
| reset_n | output | 1 | Processor reset, active low |
| reset_end | output | 1 | One-cycle strobe when reset releases |
| low_line_out | output | 1 | Registered copy of low_line |
| ce_out_n | output | 1 | Gated chip-enable, active low |
| pf_out_n | output | 1 | Power-fail flag, active low |

## Verification
Suppose the tick counter holds a wrong value, or is not cleared when `low_line` returns. This becomes visible only at release: `reset` falls a different number of ticks after the last supply fault. The bench counts ticks exactly around each release edge and looks one tick before and at the release. If a watchdog request reaches the counter while reset is already asserted, the release moves, and that shows up on the edge where the unaffected count would end. The gate flags and `reset_end` are wrong on the very next clock edge, so those are checked one cycle after each stimulus.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef struct packed {
    logic ce_n;
    logic pf_n;
    logic ll;
  } supv_gate_t;

  localparam supv_gate_t GATE_RST = '{ce_n: 1'b1, pf_n: 1'b0, ll: 1'b1};
endpackage

// File: rtl/supv_stretcher.sv
module supv_stretcher #(
  parameter int STRETCH_TICKS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic wd_req,
  output logic rst_hi,
  output logic rst_lo,
  output logic rel_strobe
);
  localparam int CNT_W = (STRETCH_TICKS > 1) ? $clog2(STRETCH_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STRETCH_TICKS - 1);

  logic             busy, busy_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             rel_nx;

  always_comb begin
    busy_nx = busy;
    cnt_nx  = cnt;
    rel_nx  = 1'b0;
    if (hold) begin
      busy_nx = 1'b1;
      cnt_nx  = '0;
    end else if (busy) begin
      if (tick) begin
        if (cnt == LAST) begin
          busy_nx = 1'b0;
          cnt_nx  = '0;
          rel_nx  = 1'b1;
        end else begin
          cnt_nx = cnt + CNT_W'(1);
        end
      end
    end else if (wd_req) begin
      busy_nx = 1'b1;
      cnt_nx  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b1;
      cnt        <= '0;
      rst_hi     <= 1'b1;
      rst_lo     <= 1'b0;
      rel_strobe <= 1'b0;
    end else begin
      busy       <= busy_nx;
      cnt        <= cnt_nx;
      rst_hi     <= busy_nx;
      rst_lo     <= ~busy_nx;
      rel_strobe <= rel_nx;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    hold |=> rst_hi);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_compl_R4: assert property (@(posedge clk) disable iff (rst)
    rst_hi != rst_lo);
  assert_hold_clears_R8: assert property (@(posedge clk) disable iff (rst)
    hold |=> cnt == '0);
  assert_wd_noextend_R9: assert property (@(posedge clk) disable iff (rst)
    (rst_hi && wd_req && !hold && !tick) |=> (cnt == $past(cnt) && rst_hi));
  assert_end_R10: assert property (@(posedge clk) disable iff (rst)
    rel_strobe |-> (!rst_hi && $past(rst_hi)));
  assert_end_once_R10: assert property (@(posedge clk) disable iff (rst)
    rel_strobe |=> !rel_strobe);
endmodule

// File: rtl/supv_gate.sv
module supv_gate
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       low_line,
  input  logic       on_battery,
  input  logic       pfi_low,
  input  logic       ce_in_n,
  output supv_gate_t gate_q
);
  supv_gate_t gate_nx;

  always_comb begin
    gate_nx.ce_n = ce_in_n | low_line | on_battery;
    gate_nx.pf_n = ~(pfi_low | on_battery);
    gate_nx.ll   = low_line;
  end

  always_ff @(posedge clk) begin
    if (rst) gate_q <= GATE_RST;
    else     gate_q <= gate_nx;
  end

  assert_ce_block_R5: assert property (@(posedge clk) disable iff (rst)
    (low_line || on_battery) |=> gate_q.ce_n);
  assert_pf_batt_R6: assert property (@(posedge clk) disable iff (rst)
    on_battery |=> !gate_q.pf_n);
  assert_ll_hi_R7: assert property (@(posedge clk) disable iff (rst)
    low_line |=> gate_q.ll);
  assert_ll_lo_R7: assert property (@(posedge clk) disable iff (rst)
    !low_line |=> !gate_q.ll);
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int STRETCH_TICKS = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic low_line,
  input  logic on_battery,
  input  logic pfi_low,
  input  logic wd_req,
  input  logic ce_in_n,
  output logic reset,
  output logic reset_n,
  output logic reset_end,
  output logic low_line_out,
  output logic ce_out_n,
  output logic pf_out_n
);
  logic       supply_bad;
  supv_gate_t gate_q;

  assign supply_bad = low_line | on_battery;

  supv_stretcher #(.STRETCH_TICKS(STRETCH_TICKS)) u_stretch (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .hold       (supply_bad),
    .wd_req     (wd_req),
    .rst_hi     (reset),
    .rst_lo     (reset_n),
    .rel_strobe (reset_end)
  );

  supv_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .low_line   (low_line),
    .on_battery (on_battery),
    .pfi_low    (pfi_low),
    .ce_in_n    (ce_in_n),
    .gate_q     (gate_q)
  );

  assign ce_out_n     = gate_q.ce_n;
  assign pf_out_n     = gate_q.pf_n;
  assign low_line_out = gate_q.ll;
endmodule

// File: tb/supv_reset_gen_tb.sv
module supv_reset_gen_tb;
  localparam int N = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, low_line = 1'b0, on_battery = 1'b0, pfi_low = 1'b0;
  logic wd_req = 1'b0, ce_in_n = 1'b1;
  logic reset, reset_n, reset_end, low_line_out, ce_out_n, pf_out_n;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  supv_reset_gen #(.STRETCH_TICKS(N)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .low_line(low_line),
    .on_battery(on_battery), .pfi_low(pfi_low), .wd_req(wd_req),
    .ce_in_n(ce_in_n), .reset(reset), .reset_n(reset_n),
    .reset_end(reset_end), .low_line_out(low_line_out),
    .ce_out_n(ce_out_n), .pf_out_n(pf_out_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      cyc();
    end
    tick = 1'b0;
  endtask

  task automatic chk_rst(input string req, input logic exp);
    chk(req, reset, exp);
    chk({req, " R4"}, reset_n, ~exp);
  endtask

  task automatic t_reset_state();
    cyc();
    chk_rst("R11", 1'b1);
    chk("R11 ce", ce_out_n, 1'b1);
    chk("R11 pf", pf_out_n, 1'b0);
    chk("R11 ll", low_line_out, 1'b1);
    chk("R11 end", reset_end, 1'b0);
    rst = 1'b0;
    cyc();
    chk_rst("R11 pending", 1'b1);
    ticks(N - 1);
    chk_rst("R11 before release", 1'b1);
    ticks(1);
    chk_rst("R2 release", 1'b0);
    chk("R10 strobe", reset_end, 1'b1);
    cyc();
    chk("R10 strobe one cycle", reset_end, 1'b0);
  endtask

  task automatic t_lowline_hold();
    low_line = 1'b1;
    cyc();
    chk_rst("R1 assert", 1'b1);
    chk("R7 follow hi", low_line_out, 1'b1);
    ticks(20);
    chk_rst("R1 held", 1'b1);
    low_line = 1'b0;
    cyc();
    chk("R7 follow lo", low_line_out, 1'b0);
    ticks(N - 1);
    chk_rst("R1 ticks ignored R2", 1'b1);
    ticks(1);
    chk_rst("R2 exact release", 1'b0);
    chk("R10 strobe", reset_end, 1'b1);
  endtask

  task automatic t_stretch_restart();
    low_line = 1'b1;
    cyc();
    low_line = 1'b0;
    ticks(300);
    chk_rst("R8 mid stretch", 1'b1);
    low_line = 1'b1;
    tick = 1'b1;
    cyc();
    tick = 1'b0;
    low_line = 1'b0;
    ticks(N - 1);
    chk_rst("R8 restarted", 1'b1);
    chk("R10 no early strobe", reset_end, 1'b0);
    ticks(1);
    chk_rst("R8 release", 1'b0);
  endtask

  task automatic t_watchdog_idle();
    cyc();
    chk_rst("R3 idle", 1'b0);
    wd_req = 1'b1;
    cyc();
    wd_req = 1'b0;
    chk_rst("R3 pulse start", 1'b1);
    ticks(N - 1);
    chk_rst("R3 width", 1'b1);
    ticks(1);
    chk_rst("R3 release", 1'b0);
    chk("R10 strobe wd", reset_end, 1'b1);
  endtask

  task automatic t_watchdog_ignored();
    low_line = 1'b1;
    cyc();
    cyc();
    low_line = 1'b0;
    ticks(100);
    wd_req = 1'b1;
    cyc();
    wd_req = 1'b0;
    ticks(N - 101);
    chk_rst("R9 still asserted", 1'b1);
    ticks(1);
    chk_rst("R9 unchanged release", 1'b0);
    cyc();
    chk_rst("R9 no extra pulse", 1'b0);
  endtask

  task automatic t_gating();
    ce_in_n = 1'b0;
    cyc();
    chk("R5 pass low", ce_out_n, 1'b0);
    ce_in_n = 1'b1;
    cyc();
    chk("R5 pass high", ce_out_n, 1'b1);
    ce_in_n = 1'b0;
    low_line = 1'b1;
    cyc();
    chk("R5 blocked lowline", ce_out_n, 1'b1);
    low_line = 1'b0;
    on_battery = 1'b1;
    cyc();
    chk("R5 blocked battery", ce_out_n, 1'b1);
    chk("R6 forced battery", pf_out_n, 1'b0);
    chk_rst("R1 battery", 1'b1);
    on_battery = 1'b0;
    cyc();
    chk("R5 pass again", ce_out_n, 1'b0);
    chk("R6 idle", pf_out_n, 1'b1);
    pfi_low = 1'b1;
    cyc();
    chk("R6 pfi low", pf_out_n, 1'b0);
    pfi_low = 1'b0;
    cyc();
    chk("R6 pfi clear", pf_out_n, 1'b1);
    ce_in_n = 1'b1;
    ticks(N);
    chk_rst("R2 after battery", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL all: watchdog expired, actual hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_lowline_hold();
    t_stretch_restart();
    t_watchdog_idle();
    t_watchdog_ignored();
    t_gating();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule